// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a synchronous host and an asynchronous extended-data-out DRAM with a narrow data path and a multiplexed row/column address bus. It turns host requests (single reads, early writes, and bursts of column accesses within one open row) into the row strobe, column strobe, write strobe and output-enable sequences. It also drives the matching row or column address onto the shared bus. Every interval is a whole number of clock cycles set by a parameter. All strobes are registered and active-low.

A request is a valid/ready transfer that carries a row+column address, a write flag, write data and a last-in-burst flag. A request with the last flag clear leaves the row open. The next request is then served as a column-only access, and the row strobe stays low. Read data is captured a fixed number of clocks after the column strobe falls, so the capture can land after the strobe has risen again while the DRAM still holds the data. The host sees a one-cycle read-valid pulse. An external refresh arbiter raises a request. The controller closes any open row, returns a grant, and accepts no host traffic until the request drops. An open row is also closed on the controller's own initiative before the maximum row-low time runs out.

The state machine has nine states:
- **ST_IDLE**: row strobe high, precharge done. Goes to ST_REF_HOLD on a refresh request, or to ST_ROW_SET when it accepts a host request.
- **ST_ROW_SET**: row address on the bus, for the setup time. Then goes to ST_ROW_HOLD, where the row strobe falls.
- **ST_ROW_HOLD**: row address held. Then goes to ST_COL_SET.
- **ST_COL_SET**: column address on the bus, write strobe low for a write. Then goes to ST_CAS_ACT.
- **ST_CAS_ACT**: column strobe low. Then goes to ST_CAS_PRE.
- **ST_CAS_PRE**: column precharge. Then goes to ST_RAS_PRE if the last flag is set, the row-age limit is reached or refresh is pending; otherwise it goes to ST_PAGE_WAIT.
- **ST_PAGE_WAIT**: row held open. Goes to ST_COL_SET on the next request, or to ST_RAS_PRE on refresh or row-age expiry.
- **ST_RAS_PRE**: row strobe high. Goes to ST_IDLE after the precharge time.
- **ST_REF_HOLD**: grant high. Goes to ST_IDLE when the refresh request drops.

Top module: `edo_ctrl`

## Requirements
- R1: Out of reset all four strobes are high, `dram_addr` and `dram_dq_o` are 0, `ref_gnt` and `rd_valid` are low, and `req_ready` is high when `ref_req` is low.
- R2: Address timing:
  - the row address is stable on `dram_addr` for at least ASR_CYC cycles before `dram_ras_n` falls;
  - the bus does not change to the column address until RAH_CYC cycles after that fall;
  - the column address is stable for at least ASC_CYC cycles before `dram_cas_n` falls;
  - `dram_cas_n` falls only while `dram_ras_n` is low, and at least RAH_CYC+ASC_CYC cycles after it fell.
- R3: For a write (`req_write`=1), `dram_we_n` is already low in the cycle before `dram_cas_n` falls and `dram_oe_n` stays high. The model latches `dram_dq_o` at the falling edge of the column strobe.
- R4: For a read (`req_write`=0), `dram_oe_n` is low. `rd_valid` is a one-cycle pulse exactly CAP_DLY cycles after `dram_cas_n` falls, and `rd_data` equals the DRAM data at that edge.
- R5: When a request has `req_last`=0, the row stays open. Later requests are column accesses in the same row with no new fall of `dram_ras_n`; reads and writes may be mixed.
- R6: Between column accesses in one open row, `dram_cas_n` stays high for at least CP_CYC cycles.
- R7: `dram_ras_n` is never low for more than RAS_MAX_CYC cycles. An ongoing burst has its row closed, and the next request reopens a row using its own row address.
- R8: `dram_ras_n` stays high at least RP_CYC cycles between rows, and successive falls of `dram_ras_n` are at least RC_CYC cycles apart.
- R9: Refresh handshake:
  - while `ref_req` is high, `req_ready` is low;
  - from ST_IDLE, `ref_gnt` rises one cycle after `ref_req`;
  - from an open row, the row is closed first and `ref_gnt` is only high with all strobes high;
  - `ref_gnt` drops one cycle after `ref_req` drops.
- R10: A request with `req_last`=1 closes the row: `dram_ras_n` rises after the column precharge of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_last | input | 1 | 1 = close the row after this access |
| req_addr | input | ROW_W+COL_W | Row in the upper bits, column in the lower bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Captured read data |
| ref_req | input | 1 | Refresh arbiter request |
| ref_gnt | output | 1 | DRAM handed to the refresh arbiter |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_o | output | DATA_W | Write data toward the DRAM |
| dram_dq_i | input | DATA_W | Read data from the DRAM |

## Verification
For an access from ST_IDLE accepted at edge e, the row strobe falls at e+ASR_CYC and the column strobe at e+ASR_CYC+RAH_CYC+ASC_CYC; a page access in ST_PAGE_WAIT sees its column strobe fall ASC_CYC cycles after acceptance. The read pulse is due exactly CAP_DLY cycles after the column strobe falls, and the row strobe rises CAS_CYC+CP_CYC cycles after that fall when the last flag is set. The grant follows the refresh request by one cycle from idle. The bench samples all outputs on the falling clock edge with a free-running cycle count, and compares the measured interval between strobe events against these counts. It checks equality only where the state machine fixes the latency: read capture and grant timing. Where the host's pace can stretch an interval (setup, hold, precharge, cycle time, row age), it checks a lower or upper bound.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW_SET,
        ST_ROW_HOLD,
        ST_COL_SET,
        ST_CAS_ACT,
        ST_CAS_PRE,
        ST_PAGE_WAIT,
        ST_RAS_PRE,
        ST_REF_HOLD
    } edo_state_e;

endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             done
);
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_span.sv
module edo_span #(
    parameter int SPAN_MAX = 20000,
    localparam int SPAN_W  = $clog2(SPAN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    output logic [SPAN_W-1:0] span
);
    localparam logic [SPAN_W-1:0] TOP_V = SPAN_W'(SPAN_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            span <= TOP_V;
        else if (clr)
            span <= '0;
        else if (span != TOP_V)
            span <= span + 1'b1;
    end
endmodule

// File: rtl/edo_rdcap.sv
module edo_rdcap #(
    parameter int DATA_W  = 4,
    parameter int CAP_DLY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [CAP_DLY-1:0] pipe_q;

    generate
        if (CAP_DLY == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= start;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[CAP_DLY-2:0], start};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= pipe_q[CAP_DLY-1];
            if (pipe_q[CAP_DLY-1])
                rd_data <= dq_i;
        end
    end

    // R4
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W       = 11,
    parameter int COL_W       = 11,
    parameter int DATA_W      = 4,
    parameter int TMR_W       = 8,
    parameter int ASR_CYC     = 1,
    parameter int RAH_CYC     = 1,
    parameter int ASC_CYC     = 1,
    parameter int CAS_CYC     = 2,
    parameter int CP_CYC      = 1,
    parameter int RP_CYC      = 3,
    parameter int RC_CYC      = 9,
    parameter int CAP_DLY     = 3,
    parameter int RAS_MAX_CYC = 20000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic                     req_last,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     ref_req,
    output logic                     ref_gnt,
    output logic                     dram_ras_n,
    output logic                     dram_cas_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DATA_W-1:0]        dram_dq_o,
    input  logic [DATA_W-1:0]        dram_dq_i
);
    localparam int ADDR_W   = ROW_W + COL_W;
    localparam int BUS_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int SPAN_MAX = (RAS_MAX_CYC > RC_CYC) ? RAS_MAX_CYC : RC_CYC;
    localparam int SPAN_W   = $clog2(SPAN_MAX + 1);
    localparam int ACC_CYC  = ASC_CYC + CAS_CYC + CP_CYC + 2;
    localparam logic [SPAN_W-1:0] EXP_V   = SPAN_W'(RAS_MAX_CYC - ACC_CYC);
    localparam logic [SPAN_W-1:0] GATE_V  = SPAN_W'(RC_CYC - ASR_CYC - 1);
    localparam logic [SPAN_W-1:0] RCM1_V  = SPAN_W'(RC_CYC - 1);
    localparam logic [SPAN_W-1:0] RMAX_V  = SPAN_W'(RAS_MAX_CYC);

    edo_state_e state_q, state_n;

    logic [TMR_W-1:0]  dur_m1;
    logic              tmr_done;
    logic [SPAN_W-1:0] span;
    logic              span_clr;
    logic              rc_ok, expire, accept, cap_start;

    logic [ADDR_W-1:0] addr_q, cur_addr;
    logic [DATA_W-1:0] wdata_q, cur_wdata;
    logic              wr_q, last_q, cur_wr;
    logic              ras_n_q, cas_n_q, we_n_q, oe_n_q, gnt_q;
    logic [BUS_W-1:0]  bus_q;
    logic [DATA_W-1:0] dq_q;

    // ---------------- sub-blocks ----------------
    edo_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(state_n != state_q),
        .load_val(dur_m1), .done(tmr_done));

    edo_span #(.SPAN_MAX(SPAN_MAX)) u_span (
        .clk(clk), .rst_n(rst_n), .clr(span_clr), .span(span));

    edo_rdcap #(.DATA_W(DATA_W), .CAP_DLY(CAP_DLY)) u_rdcap (
        .clk(clk), .rst_n(rst_n), .start(cap_start), .dq_i(dram_dq_i),
        .rd_data(rd_data), .rd_valid(rd_valid));

    // ---------------- request side ----------------
    assign rc_ok     = (span >= GATE_V);
    assign expire    = !ras_n_q && (span >= EXP_V);
    assign req_ready = !ref_req &&
                       (((state_q == ST_IDLE) && rc_ok) ||
                        ((state_q == ST_PAGE_WAIT) && !expire));
    assign accept    = req_ready && req_valid;
    assign cur_addr  = accept ? req_addr  : addr_q;
    assign cur_wr    = accept ? req_write : wr_q;
    assign cur_wdata = accept ? req_wdata : wdata_q;
    assign span_clr  = (state_q == ST_ROW_SET) && (state_n == ST_ROW_HOLD);
    assign cap_start = (state_q == ST_COL_SET) && (state_n == ST_CAS_ACT) && !wr_q;

    // ---------------- next state ----------------
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_req)     state_n = ST_REF_HOLD;
                else if (accept) state_n = ST_ROW_SET;
            end
            ST_ROW_SET:  if (tmr_done) state_n = ST_ROW_HOLD;
            ST_ROW_HOLD: if (tmr_done) state_n = ST_COL_SET;
            ST_COL_SET:  if (tmr_done) state_n = ST_CAS_ACT;
            ST_CAS_ACT:  if (tmr_done) state_n = ST_CAS_PRE;
            ST_CAS_PRE: begin
                if (tmr_done)
                    state_n = (last_q || expire || ref_req) ? ST_RAS_PRE : ST_PAGE_WAIT;
            end
            ST_PAGE_WAIT: begin
                if (ref_req || expire) state_n = ST_RAS_PRE;
                else if (accept)       state_n = ST_COL_SET;
            end
            ST_RAS_PRE:  if (tmr_done) state_n = ST_IDLE;
            ST_REF_HOLD: if (!ref_req) state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_n)
            ST_ROW_SET:  dur_m1 = TMR_W'(ASR_CYC - 1);
            ST_ROW_HOLD: dur_m1 = TMR_W'(RAH_CYC - 1);
            ST_COL_SET:  dur_m1 = TMR_W'(ASC_CYC - 1);
            ST_CAS_ACT:  dur_m1 = TMR_W'(CAS_CYC - 1);
            ST_CAS_PRE:  dur_m1 = TMR_W'(CP_CYC - 1);
            ST_RAS_PRE:  dur_m1 = TMR_W'(RP_CYC - 1);
            default:     dur_m1 = '0;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            last_q  <= 1'b0;
            ras_n_q <= 1'b1;
            cas_n_q <= 1'b1;
            we_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            gnt_q   <= 1'b0;
            bus_q   <= '0;
            dq_q    <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                wr_q    <= req_write;
                last_q  <= req_last;
            end
            ras_n_q <= !(state_n inside {ST_ROW_HOLD, ST_COL_SET, ST_CAS_ACT,
                                         ST_CAS_PRE, ST_PAGE_WAIT});
            cas_n_q <= (state_n != ST_CAS_ACT);
            we_n_q  <= !(cur_wr && (state_n inside {ST_COL_SET, ST_CAS_ACT}));
            oe_n_q  <= !(!cur_wr && (state_n inside {ST_COL_SET, ST_CAS_ACT,
                                                     ST_CAS_PRE, ST_PAGE_WAIT}));
            gnt_q   <= (state_n == ST_REF_HOLD);
            if ((state_n == ST_ROW_SET) && (state_q != ST_ROW_SET))
                bus_q <= BUS_W'(cur_addr[ADDR_W-1:COL_W]);
            if ((state_n == ST_COL_SET) && (state_q != ST_COL_SET)) begin
                bus_q <= BUS_W'(cur_addr[COL_W-1:0]);
                dq_q  <= cur_wdata;
            end
        end
    end

    assign dram_ras_n = ras_n_q;
    assign dram_cas_n = cas_n_q;
    assign dram_we_n  = we_n_q;
    assign dram_oe_n  = oe_n_q;
    assign dram_addr  = bus_q;
    assign dram_dq_o  = dq_q;
    assign ref_gnt    = gnt_q;

    // ---------------- assertions ----------------
    // R2
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n_q) |-> (!ras_n_q && !$past(ras_n_q)));

    // R3
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n_q) && !we_n_q) |-> (!$past(we_n_q) && oe_n_q));

    // R7
    row_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_q |-> (span < RMAX_V));

    // R8
    row_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_q) |-> ($past(span) >= RCM1_V));

    // R9
    grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_q |-> (ras_n_q && cas_n_q && !req_ready));
endmodule

// File: tb/edo_ctrl_tb.sv
module edo_ctrl_tb;
    localparam int RW = 4, CW = 4, DW = 4;
    localparam int ASR = 1, RAH = 1, ASC = 1, CASC = 2, CP = 1;
    localparam int RP = 3, RC = 14, CAP = 3, RMAX = 30;
    localparam int NVEC = 13;

    // {write, last, row[3:0], col[3:0], data/expected[3:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 4'h1, 4'h2, 4'h5},
        {1'b1, 1'b1, 4'h3, 4'h4, 4'hA},
        {1'b0, 1'b1, 4'h3, 4'h4, 4'hA},
        {1'b0, 1'b1, 4'h1, 4'h2, 4'h5},
        {1'b1, 1'b0, 4'h2, 4'h0, 4'h1},
        {1'b1, 1'b0, 4'h2, 4'h1, 4'h2},
        {1'b1, 1'b1, 4'h2, 4'h2, 4'h3},
        {1'b0, 1'b0, 4'h2, 4'h2, 4'h3},
        {1'b0, 1'b0, 4'h2, 4'h0, 4'h1},
        {1'b0, 1'b1, 4'h2, 4'h1, 4'h2},
        {1'b1, 1'b0, 4'h5, 4'h7, 4'hF},
        {1'b0, 1'b1, 4'h5, 4'h7, 4'hF},
        {1'b0, 1'b1, 4'h3, 4'h4, 4'hA}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_last = 1'b0, ref_req = 1'b0;
    logic [RW+CW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, ref_gnt, ras_n, cas_n, we_n, oe_n;
    logic [DW-1:0] rd_data, dq_o, dq_i;
    logic [3:0] dram_addr;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    edo_ctrl #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .ASR_CYC(ASR), .RAH_CYC(RAH),
               .ASC_CYC(ASC), .CAS_CYC(CASC), .CP_CYC(CP), .RP_CYC(RP), .RC_CYC(RC),
               .CAP_DLY(CAP), .RAS_MAX_CYC(RMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_last(req_last), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr),
        .dram_dq_o(dq_o), .dram_dq_i(dq_i));

    // ---------------- DRAM model ----------------
    logic [3:0] mem [256];
    logic [3:0] row_l = '0;
    logic [3:0] dout = '0;
    assign dq_i = dout;

    initial for (int i = 0; i < 256; i++) mem[i] = '0;

    always @(negedge ras_n) row_l = dram_addr;
    always @(negedge cas_n) begin
        if (!ras_n) begin
            if (!we_n) mem[{row_l, dram_addr}] = dq_o;
            else       dout = mem[{row_l, dram_addr}];
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // ---------------- port monitor ----------------
    int cyc = 0, falls = 0;
    int ras_fall_c = -100, ras_rise_c = -100, cas_fall_c = -100;
    int cas_rise_c = -100, addr_chg_c = -100;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, mon_en = 1'b0;
    logic [3:0] p_addr = '0;

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (dram_addr != p_addr) begin
                if (!ras_n && !p_ras)
                    chk(cyc - ras_fall_c >= RAH, "R2 row hold before column", cyc - ras_fall_c, RAH);
                addr_chg_c = cyc;
            end
            if (p_ras && !ras_n) begin
                chk(cyc - addr_chg_c >= ASR, "R2 row setup", cyc - addr_chg_c, ASR);
                chk(cyc - ras_rise_c >= RP, "R8 row precharge", cyc - ras_rise_c, RP);
                chk(cyc - ras_fall_c >= RC, "R8 row cycle", cyc - ras_fall_c, RC);
                ras_fall_c = cyc;
                falls++;
            end
            if (!p_ras && ras_n) begin
                chk(cyc - ras_fall_c <= RMAX, "R7 row age", cyc - ras_fall_c, RMAX);
                ras_rise_c = cyc;
            end
            if (p_cas && !cas_n) begin
                chk(!ras_n && (cyc - ras_fall_c >= RAH + ASC), "R2 column strobe delay",
                    cyc - ras_fall_c, RAH + ASC);
                chk(cyc - addr_chg_c >= ASC, "R2 column setup", cyc - addr_chg_c, ASC);
                chk(cyc - cas_rise_c >= CP, "R6 column precharge", cyc - cas_rise_c, CP);
                if (!we_n) chk(!p_we && oe_n, "R3 early write", int'(p_we), 0);
                cas_fall_c = cyc;
            end
            if (!p_cas && cas_n) cas_rise_c = cyc;
            if (rd_valid)
                chk(cyc - cas_fall_c == CAP, "R4 capture delay", cyc - cas_fall_c, CAP);
            if (ref_gnt)
                chk(!req_ready && ras_n && cas_n, "R9 grant exclusivity", int'(req_ready), 0);
        end
        p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = dram_addr;
    end

    // ---------------- host tasks ----------------
    task automatic send(input bit wr, input bit last, input logic [3:0] row,
                        input logic [3:0] col, input logic [3:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_last = last;
        req_addr = {row, col}; req_wdata = data;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rd(output logic [3:0] d, output bit ok);
        ok = 1'b0; d = '0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (rd_valid) begin d = rd_data; ok = 1'b1; break; end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] d;
        bit ok;
        int f0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset", int'({ras_n, cas_n, we_n, oe_n}), 15);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        chk(ras_n && cas_n && we_n && oe_n, "R1 strobes after reset", int'({ras_n, cas_n, we_n, oe_n}), 15);
        chk(!ref_gnt && !rd_valid, "R1 grant and read-valid low", int'({ref_gnt, rd_valid}), 0);
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
        chk(dram_addr == 0 && dq_o == 0, "R1 buses zero", int'(dram_addr), 0);

        // table walk: R3 writes, R4 reads, R5 page bursts
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7:4], VEC[i][3:0]);
            if (!VEC[i][13]) begin
                wait_rd(d, ok);
                chk(ok && d == VEC[i][3:0], "R4 R5 table read data", int'(d), int'(VEC[i][3:0]));
            end
        end

        // R5 and R10: a four-write burst opens one row and closes it after the last
        f0 = falls;
        send(1'b1, 1'b0, 4'h4, 4'h0, 4'h6);
        send(1'b1, 1'b0, 4'h4, 4'h1, 4'h7);
        send(1'b1, 1'b0, 4'h4, 4'h2, 4'h8);
        send(1'b1, 1'b1, 4'h4, 4'h3, 4'h9);
        repeat (6) @(negedge clk);
        chk(ras_n, "R10 row closed after last", int'(ras_n), 1);
        chk(falls - f0 == 1, "R5 single row strobe in burst", falls - f0, 1);
        send(1'b0, 1'b1, 4'h4, 4'h3, 4'h0);
        wait_rd(d, ok);
        chk(ok && d == 4'h9, "R3 burst write read back", int'(d), 9);

        // R7: long read burst is cut by the row-age limit and resumes
        f0 = falls;
        for (int i = 0; i < 9; i++) begin
            send(1'b0, i == 8, 4'h2, 4'(i % 3), 4'h0);
            wait_rd(d, ok);
            chk(ok && d == 4'(i % 3 + 1), "R7 data across forced close", int'(d), i % 3 + 1);
        end
        chk(falls - f0 >= 2, "R7 row reopened", falls - f0, 2);

        // R9: refresh from idle
        repeat (20) @(negedge clk);
        ref_req = 1'b1;
        #1 chk(!req_ready, "R9 ready drops with request", int'(req_ready), 0);
        @(negedge clk);
        chk(ref_gnt && ras_n, "R9 grant one cycle after request", int'(ref_gnt), 1);
        ref_req = 1'b0;
        @(negedge clk);
        chk(!ref_gnt, "R9 grant release", int'(ref_gnt), 0);

        // R9: refresh while a row is open
        send(1'b0, 1'b0, 4'h1, 4'h2, 4'h0);
        wait_rd(d, ok);
        chk(ok && d == 4'h5, "R9 read before refresh", int'(d), 5);
        @(negedge clk);
        ref_req = 1'b1;
        #1 chk(!req_ready, "R9 ready low in open row", int'(req_ready), 0);
        ok = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (ref_gnt) begin ok = 1'b1; break; end
        end
        chk(ok && ras_n, "R9 row closed before grant", int'(ras_n), 1);
        ref_req = 1'b0;
        send(1'b0, 1'b1, 4'h1, 4'h2, 4'h0);
        wait_rd(d, ok);
        chk(ok && d == 4'h5, "R9 read after refresh", int'(d), 5);

        repeat (10) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule